// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches bytes between serial time-division streams. Every input channel is turned into a byte and stored at its own address of a shared sample memory. A connection table has one entry per output channel. Each entry names the sample address to send out on that channel and whether the channel drives at all. The chosen bytes are turned back into serial form on the output streams. Any input channel can reach any output channel, so no connection blocks another.

Two kinds of stream share the one sample memory. The backplane group is a set of fixed-rate streams at 2.048 Mb/s. The local group is four pins that can run as four streams at 2.048 Mb/s, two streams at 4.096 Mb/s or one stream at 8.192 Mb/s. In every rate the local group carries the same 128 channels. The clock runs at the fastest bit rate. A frame pulse marks the start of each 125 µs frame.

A host port reads and writes both the sample memory and the connection table while traffic is running. A connection change takes hold the next time that output channel is fetched. Traffic on the other channels is not disturbed.

Top module: `tsi_switch`

## Requirements
- R1: After reset every serial output line is 1 and every output-enable indication is 0. Every connection entry reads back as 0, which means disabled with source 0.
- R2: The clock cycle in which frame_sync is high is frame position 0, and a frame has 1024 clocks. Slot t covers positions 32t to 32t+31. A backplane bit lasts 4 clocks, bits are sent MSB first, and backplane channel c sits in slot c.
- R3: Backplane input stream s, channel c is stored at sample address s*32+c. Backplane output stream s, channel c is output channel s*32+c.
- R4: The rate code selects the local mode: 0 or 3 gives four lanes at 4 clocks per bit, 1 gives two lanes at 2 clocks per bit, and 2 gives one lane at 1 clock per bit. The local channel L sits at sample address 256+L, and output channel 256+L uses the same mapping. In code 0 or 3, lane i channel c is L=32i+c. In code 1, lane i channel c is L=64i+c and occupies half c%2 of slot c/2. In code 2, lane 0 channel c is L=c and occupies quarter c%4 of slot c/4. Lanes unused in a mode ignore their inputs and keep their outputs at 1 with the enable at 0.
- R5: A connection entry is 10 bits. Bits 8:0 hold the source sample address and bit 9 is the output enable. An enabled output channel sends the stored byte of its source.
- R6: An output channel whose entry has bit 9 clear drives its line to 1 with the enable indication at 0 for the whole channel time.
- R7: A host write to the connection table (host_cm=1) is returned by a host read one cycle later. It takes effect on the output from the next fetch of that channel, and other channels are unaffected.
- R8: A host write to the sample memory (host_cm=0) is replaced by the next serial sample for that address. A serial write and a host write to the same address in the same cycle leave the serial byte. A host read of the sample memory returns the latest stored byte in bits 7:0.
- R9: Host writes to addresses 384 and above change nothing, and host reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock at the fastest serial rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the cycle at frame position 0 |
| rate | input | 2 | Local lane rate code |
| bp_rx | input | BP_STREAMS | Backplane serial inputs |
| loc_rx | input | 4 | Local serial inputs |
| bp_tx | output | BP_STREAMS | Backplane serial outputs |
| bp_tx_en | output | BP_STREAMS | Backplane output-enable indications |
| loc_tx | output | 4 | Local serial outputs |
| loc_tx_en | output | 4 | Local output-enable indications |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_cm | input | 1 | Select connection table (1) or sample memory (0) |
| host_addr | input | AW | Host address |
| host_wdata | input | AW+1 | Host write data |
| host_rdata | output | AW+1 | Host read data, one cycle after the strobe |

## Verification
The bench checks every output line against a behavioural frame model on every clock, in each of the four rate codes. A wrong lane mapping or a half- or quarter-slot offset in the 4.096 or 8.192 Mb/s modes would put bytes on the wrong positions. A lane left over from a previous mode would keep driving when it should be idle. Entries with the enable bit clear are mixed through the table, so a design that ignored bit 9 would send data where the line should sit at 1. The bench also rewrites connections while traffic runs, overwrites a sample from the host and probes addresses past 383. A stale fetch, a host write that survives the serial write, or address aliasing would each show up as a wrong byte at a known frame position or a wrong read-back value.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int BYTE_W   = 8;
   localparam int SLOT_CYC = 32;
   localparam int SUBCH    = 4;

   typedef enum logic [1:0] {
      RATE_2M  = 2'd0,
      RATE_4M  = 2'd1,
      RATE_8M  = 2'd2,
      RATE_ALT = 2'd3
   } rate_e;

   typedef struct packed {
      logic              en;
      logic [BYTE_W-1:0] data;
   } txw_t;

   function automatic rate_e norm_rate(logic [1:0] r);
      return (r == 2'd3) ? RATE_2M : rate_e'(r);
   endfunction
endpackage

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sample,
   input  logic         din,
   output logic [W-1:0] word
);
   logic [W-2:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n)      sh <= '0;
      else if (sample) sh <= word[W-2:0];
   end

   assign word = {sh, din};
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         load,
   input  logic [W-1:0] ld_data,
   input  logic         ld_en,
   input  logic         shift,
   output logic         dout,
   output logic         en_o
);
   logic [W-1:0] sh;
   logic         en_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         sh   <= '1;
         en_q <= 1'b0;
      end else if (load) begin
         sh   <= ld_data;
         en_q <= ld_en;
      end else if (shift) begin
         sh   <= {sh[W-2:0], 1'b1};
      end
   end

   assign dout = en_q ? sh[W-1] : 1'b1;
   assign en_o = en_q;
endmodule

// File: rtl/tsi_store.sv
module tsi_store #(
   parameter int TOTAL = 384,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_en,
   input  logic [AW-1:0] sw_addr,
   input  logic [7:0]    sw_data,
   input  logic [AW-1:0] rd_chan,
   output logic [7:0]    rd_data,
   output logic          rd_en,
   input  logic          host_en,
   input  logic          host_we,
   input  logic          host_cm,
   input  logic [AW-1:0] host_addr,
   input  logic [AW:0]   host_wdata,
   output logic [AW:0]   host_rdata
);
   logic [7:0]  smem [TOTAL];
   logic [AW:0] cmem [TOTAL];
   logic        h_in;
   logic [AW:0] entry;

   assign h_in = (int'(host_addr) < TOTAL);

   always_ff @(posedge clk) begin
      if (host_en && host_we && !host_cm && h_in) smem[host_addr] <= host_wdata[7:0];
      if (sw_en) smem[sw_addr] <= sw_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) cmem[i] <= '0;
      end else if (host_en && host_we && host_cm && h_in) begin
         cmem[host_addr] <= host_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) host_rdata <= '0;
      else if (host_en && !host_we) begin
         if (!h_in)       host_rdata <= '0;
         else if (host_cm) host_rdata <= cmem[host_addr];
         else             host_rdata <= (AW+1)'(smem[host_addr]);
      end
   end

   assign entry   = cmem[rd_chan];
   assign rd_en   = entry[AW];
   assign rd_data = (int'(entry[AW-1:0]) < TOTAL) ? smem[entry[AW-1:0]] : 8'hFF;

   // R8: serial sample wins a same-address collision with a host write
   assert_serial_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && host_en && host_we && !host_cm && host_addr == sw_addr)
      |=> smem[$past(sw_addr)] == $past(sw_data));

   // R7: an in-range table write is stored as given
   assert_cm_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && host_we && host_cm && h_in)
      |=> cmem[$past(host_addr)] == $past(host_wdata));

   // R9: out-of-range reads return zero
   assert_oob_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en && !host_we && !h_in) |=> host_rdata == '0);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
   import tsi_pkg::*;
#(
   parameter int BP_STREAMS = 8,
   parameter int SLOTS      = 32,
   parameter int AW         = $clog2((BP_STREAMS + SUBCH) * SLOTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_sync,
   input  logic [1:0]            rate,
   input  logic [BP_STREAMS-1:0] bp_rx,
   input  logic [SUBCH-1:0]      loc_rx,
   output logic [BP_STREAMS-1:0] bp_tx,
   output logic [BP_STREAMS-1:0] bp_tx_en,
   output logic [SUBCH-1:0]      loc_tx,
   output logic [SUBCH-1:0]      loc_tx_en,
   input  logic                  host_en,
   input  logic                  host_we,
   input  logic                  host_cm,
   input  logic [AW-1:0]         host_addr,
   input  logic [AW:0]           host_wdata,
   output logic [AW:0]           host_rdata
);
   localparam int BP_CH  = BP_STREAMS * SLOTS;
   localparam int LOC_CH = SUBCH * SLOTS;
   localparam int TOTAL  = BP_CH + LOC_CH;
   localparam int SW     = $clog2(SLOTS);
   localparam int PW     = SW + $clog2(SLOT_CYC);
   localparam int LW     = SW + 2;

   if (SLOTS < 2 || (1 << SW) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two");
   end
   if (BP_STREAMS < 1 || BP_STREAMS > 8) begin : g_bad_bp
      $error("BP_STREAMS must lie in 1..8 to fit the slot schedule");
   end
   if (AW != $clog2(TOTAL)) begin : g_bad_aw
      $error("AW must match the sample memory size");
   end

   // frame position
   logic [PW-1:0] cnt, pos;
   logic [4:0]    off;
   logic [SW-1:0] slot, nslot, wr_slot;
   rate_e         rmode;

   assign pos   = frame_sync ? '0 : cnt;
   assign off   = pos[4:0];
   assign slot  = pos[PW-1:5];
   assign nslot = slot + 1'b1;
   assign rmode = norm_rate(rate);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= pos + 1'b1;
   end

   function automatic logic [LW-1:0] lidx(rate_e m, logic [1:0] j, logic [SW-1:0] t);
      case (m)
         RATE_4M: return {j[1], t, j[0]};
         RATE_8M: return {t, j};
         default: return {j, t};
      endcase
   endfunction

   logic [SUBCH-1:0] lane_act;
   logic             loc_samp;
   always_comb begin
      case (rmode)
         RATE_4M: begin lane_act = 4'b0011; loc_samp = off[0];          end
         RATE_8M: begin lane_act = 4'b0001; loc_samp = 1'b1;            end
         default: begin lane_act = 4'b1111; loc_samp = (off[1:0] == 2'b11); end
      endcase
   end

   // receive side
   logic [7:0] bp_word [BP_STREAMS];
   logic [7:0] bp_latch[BP_STREAMS];
   logic [7:0] loc_word [SUBCH];
   logic [7:0] loc_latch[SUBCH];

   for (genvar s = 0; s < BP_STREAMS; s++) begin : g_bp_rx
      tsi_rx_lane #(.W(BYTE_W)) u_rx (
         .clk(clk), .rst_n(rst_n), .sample(off[1:0] == 2'b11),
         .din(bp_rx[s]), .word(bp_word[s]));
      always_ff @(posedge clk) begin
         if (!rst_n)           bp_latch[s] <= '0;
         else if (off == 5'd31) bp_latch[s] <= bp_word[s];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            wr_slot <= '0;
      else if (off == 5'd31) wr_slot <= slot;
   end

   for (genvar j = 0; j < SUBCH; j++) begin : g_loc_rx
      logic       ld;
      logic [7:0] src;
      tsi_rx_lane #(.W(BYTE_W)) u_rx (
         .clk(clk), .rst_n(rst_n), .sample(loc_samp),
         .din(loc_rx[j]), .word(loc_word[j]));
      always_comb begin
         case (rmode)
            RATE_4M: begin
               ld  = (off[3:0] == 4'd15) && (off[4] == 1'(j % 2));
               src = loc_word[j / 2];
            end
            RATE_8M: begin
               ld  = (off[2:0] == 3'd7) && (off[4:3] == 2'(j));
               src = loc_word[0];
            end
            default: begin
               ld  = (off == 5'd31);
               src = loc_word[j];
            end
         endcase
      end
      always_ff @(posedge clk) begin
         if (!rst_n)  loc_latch[j] <= '0;
         else if (ld) loc_latch[j] <= src;
      end
   end

   // sample memory write schedule: local latches at offsets 0..3, backplane after
   logic          sw_en;
   logic [AW-1:0] sw_addr;
   logic [7:0]    sw_data;
   always_comb begin
      sw_en   = 1'b0;
      sw_addr = '0;
      sw_data = '0;
      for (int j = 0; j < SUBCH; j++) begin
         if (int'(off) == j) begin
            sw_en   = 1'b1;
            sw_addr = AW'(BP_CH) + AW'(lidx(rmode, 2'(j), wr_slot));
            sw_data = loc_latch[j];
         end
      end
      for (int k = 0; k < BP_STREAMS; k++) begin
         if (int'(off) == SUBCH + k) begin
            sw_en   = 1'b1;
            sw_addr = AW'(k * SLOTS) + AW'(wr_slot);
            sw_data = bp_latch[k];
         end
      end
   end

   // fetch schedule: one slot ahead, backplane at 16.., local at 24..27
   logic [AW-1:0] rd_chan;
   logic [7:0]    rd_data;
   logic          rd_en;
   always_comb begin
      rd_chan = '0;
      for (int k = 0; k < BP_STREAMS; k++)
         if (int'(off) == 16 + k) rd_chan = AW'(k * SLOTS) + AW'(nslot);
      for (int j = 0; j < SUBCH; j++)
         if (int'(off) == 24 + j) rd_chan = AW'(BP_CH) + AW'(lidx(rmode, 2'(j), nslot));
   end

   tsi_store #(.TOTAL(TOTAL), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .sw_en(sw_en), .sw_addr(sw_addr), .sw_data(sw_data),
      .rd_chan(rd_chan), .rd_data(rd_data), .rd_en(rd_en),
      .host_en(host_en), .host_we(host_we), .host_cm(host_cm),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

   // transmit side
   txw_t bp_hold [BP_STREAMS];
   txw_t loc_hold[SUBCH];

   for (genvar k = 0; k < BP_STREAMS; k++) begin : g_bp_tx
      always_ff @(posedge clk) begin
         if (!rst_n)                bp_hold[k] <= '0;
         else if (int'(off) == 16 + k) bp_hold[k] <= '{en: rd_en, data: rd_data};
      end
      tsi_tx_lane #(.W(BYTE_W)) u_tx (
         .clk(clk), .rst_n(rst_n), .active(1'b1),
         .load(off == 5'd31), .ld_data(bp_hold[k].data), .ld_en(bp_hold[k].en),
         .shift(off[1:0] == 2'b11), .dout(bp_tx[k]), .en_o(bp_tx_en[k]));
   end

   logic [1:0] nq;
   assign nq = off[4:3] + 2'd1;

   for (genvar i = 0; i < SUBCH; i++) begin : g_loc_tx
      logic load, shift;
      txw_t ld;
      always_ff @(posedge clk) begin
         if (!rst_n)                loc_hold[i] <= '0;
         else if (int'(off) == 24 + i) loc_hold[i] <= '{en: rd_en, data: rd_data};
      end
      always_comb begin
         case (rmode)
            RATE_4M: begin
               load  = (off[3:0] == 4'd15);
               ld    = loc_hold[(i % 2) * 2 + (off[4] ? 0 : 1)];
               shift = off[0];
            end
            RATE_8M: begin
               load  = (off[2:0] == 3'd7);
               ld    = loc_hold[nq];
               shift = 1'b1;
            end
            default: begin
               load  = (off == 5'd31);
               ld    = loc_hold[i];
               shift = (off[1:0] == 2'b11);
            end
         endcase
      end
      tsi_tx_lane #(.W(BYTE_W)) u_tx (
         .clk(clk), .rst_n(rst_n), .active(lane_act[i]),
         .load(load), .ld_data(ld.data), .ld_en(ld.en),
         .shift(shift), .dout(loc_tx[i]), .en_o(loc_tx_en[i]));

      if (i > 0) begin : g_idle_chk
         // R4: a lane outside the current mode goes quiet
         assert_idle_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_act[i] |=> !loc_tx_en[i]);
      end
   end

   // R3: the received byte closes with the bit present at the slot end
   assert_latch_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (off == 5'd31) |=> bp_latch[0][0] == $past(bp_rx[0]));

   // R5: a slot starts with the MSB of the fetched byte, or idle when disabled
   assert_slot_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (off == 5'd31) |=> (bp_tx_en[0] == $past(bp_hold[0].en)) &&
         (bp_tx[0] == ($past(bp_hold[0].en) ? $past(bp_hold[0].data[7]) : 1'b1)));
endmodule

// File: tb/tsi_switch_test.sv
module tsi_switch_test;
   localparam int BP  = 8;
   localparam int SL  = 32;
   localparam int TOT = 384;
   localparam int FR  = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_sync = 1'b0;
   logic [1:0] rate = 2'd0;
   logic [BP-1:0] bp_rx = '0, bp_tx, bp_tx_en;
   logic [3:0] loc_rx = '0, loc_tx, loc_tx_en;
   logic       host_en = 1'b0, host_we = 1'b0, host_cm = 1'b0;
   logic [8:0] host_addr = '0;
   logic [9:0] host_wdata = '0, host_rdata;

   tsi_switch #(.BP_STREAMS(BP), .SLOTS(SL)) uut (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate(rate),
      .bp_rx(bp_rx), .loc_rx(loc_rx), .bp_tx(bp_tx), .bp_tx_en(bp_tx_en),
      .loc_tx(loc_tx), .loc_tx_en(loc_tx_en), .host_en(host_en), .host_we(host_we),
      .host_cm(host_cm), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata));

   always #5 clk = ~clk;

   int checks = 0, failures = 0;
   int cyc_pos = 0;
   int rate_ref = 0;
   bit cmp_on = 0;
   logic [7:0] in_byte [TOT];
   logic [8:0] cm_src  [TOT];
   bit         cm_oe   [TOT];

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s pos=%0d actual=%0h expected=%0h", tag, cyc_pos, act, exp);
      end
   endtask

   function automatic int loc_map(int r, int lane, int p, output int b);
      int o = p % 32, t = p / 32;
      b = 0;
      if (r == 1) begin
         if (lane >= 2) return -1;
         b = (o % 16) / 2;
         return lane * 64 + 2 * t + o / 16;
      end else if (r == 2) begin
         if (lane != 0) return -1;
         b = o % 8;
         return 4 * t + o / 8;
      end
      b = o / 4;
      return lane * 32 + t;
   endfunction

   task automatic set_inputs(int ph);
      for (int a = 0; a < TOT; a++) in_byte[a] = 8'((a * 29 + ph * 71 + 3) & 255);
   endtask

   always @(posedge clk) cyc_pos <= (cyc_pos + 1) % FR;

   always @(negedge clk) begin
      int b, L, o;
      bit ee, eb;
      frame_sync = (cyc_pos == 0);
      for (int s = 0; s < BP; s++)
         bp_rx[s] = in_byte[s * 32 + cyc_pos / 32][7 - (cyc_pos % 32) / 4];
      for (int i = 0; i < 4; i++) begin
         L = loc_map(rate_ref, i, cyc_pos, b);
         loc_rx[i] = (L < 0) ? 1'b0 : in_byte[256 + L][7 - b];
      end
      if (cmp_on) begin
         for (int s = 0; s < BP; s++) begin
            o  = s * 32 + cyc_pos / 32;
            b  = (cyc_pos % 32) / 4;
            ee = cm_oe[o];
            eb = ee ? in_byte[cm_src[o]][7 - b] : 1'b1;
            chk({bp_tx_en[s], bp_tx[s]} == {ee, eb}, ee ? "R2 R3 R5" : "R6",
                {bp_tx_en[s], bp_tx[s]}, {ee, eb});
         end
         for (int i = 0; i < 4; i++) begin
            L = loc_map(rate_ref, i, cyc_pos, b);
            if (L < 0) begin ee = 0; eb = 1; end
            else begin
               o  = 256 + L;
               ee = cm_oe[o];
               eb = ee ? in_byte[cm_src[o]][7 - b] : 1'b1;
            end
            chk({loc_tx_en[i], loc_tx[i]} == {ee, eb}, ee ? "R4 R5" : "R4 R6",
                {loc_tx_en[i], loc_tx[i]}, {ee, eb});
         end
      end
   end

   task automatic host_wr(bit cmsel, int a, int d);
      @(negedge clk);
      host_en = 1; host_we = 1; host_cm = cmsel; host_addr = 9'(a); host_wdata = 10'(d);
      @(negedge clk);
      host_en = 0; host_we = 0;
   endtask

   task automatic host_rd(bit cmsel, int a, output int d);
      @(negedge clk);
      host_en = 1; host_we = 0; host_cm = cmsel; host_addr = 9'(a);
      @(negedge clk);
      host_en = 0;
      d = int'(host_rdata);
   endtask

   task automatic settle_and_compare();
      repeat (2 * FR) @(negedge clk);
      cmp_on = 1;
      repeat (FR) @(negedge clk);
      cmp_on = 0;
   endtask

   task automatic wait_pos(int p);
      do @(negedge clk); while (cyc_pos != p);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int d;
      set_inputs(0);
      for (int o = 0; o < TOT; o++) begin cm_src[o] = '0; cm_oe[o] = 0; end
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      // R1: idle outputs and cleared table
      chk(bp_tx == '1 && bp_tx_en == '0, "R1 bp", {bp_tx_en, bp_tx}, 16'h00FF);
      chk(loc_tx == '1 && loc_tx_en == '0, "R1 local", {loc_tx_en, loc_tx}, 8'h0F);
      host_rd(1, 5, d);   chk(d == 0, "R1 entry5", d, 0);
      host_rd(1, 383, d); chk(d == 0, "R1 entry383", d, 0);

      for (int o = 0; o < TOT; o++) begin
         cm_src[o] = 9'((o * 7 + 11) % TOT);
         cm_oe[o]  = (o % 13) != 5;
         host_wr(1, o, {cm_oe[o], cm_src[o]});
      end
      settle_and_compare();                       // rate 0

      set_inputs(1); rate = 2'd1; rate_ref = 1;   // R4 two lanes
      settle_and_compare();
      set_inputs(2); rate = 2'd2; rate_ref = 2;   // R4 one lane
      settle_and_compare();
      set_inputs(3); rate = 2'd3; rate_ref = 0;   // R4 code 3 as code 0
      settle_and_compare();

      // R7: read-back and live rewrites
      host_rd(1, 0, d);   chk(d == {cm_oe[0], cm_src[0]}, "R7 rd0", d, {cm_oe[0], cm_src[0]});
      host_rd(1, 100, d); chk(d == {cm_oe[100], cm_src[100]}, "R7 rd100", d, {cm_oe[100], cm_src[100]});
      cm_src[3] = 9'd383; cm_oe[3] = 1; host_wr(1, 3, {1'b1, 9'd383});
      cm_oe[300] = 0; host_wr(1, 300, {1'b0, cm_src[300]});
      host_rd(1, 3, d);   chk(d == 10'h37F, "R7 rd3", d, 10'h37F);
      settle_and_compare();
      wait_pos(3 * 32 + 1);
      chk(bp_tx_en[0] && bp_tx[0] == in_byte[383][7], "R7 out3",
          {bp_tx_en[0], bp_tx[0]}, {1'b1, in_byte[383][7]});
      wait_pos(12 * 32 + 1);
      chk(!loc_tx_en[1] && loc_tx[1], "R6 R7 out300", {loc_tx_en[1], loc_tx[1]}, 2'b01);

      // R8: host sample write is replaced by traffic
      host_wr(0, 40, ~in_byte[40]);
      repeat (FR + 100) @(negedge clk);
      host_rd(0, 40, d); chk(d == in_byte[40], "R8 overwrite", d, in_byte[40]);
      host_rd(0, 300, d); chk(d == in_byte[300], "R8 local read", d, in_byte[300]);

      // R9: out-of-range accesses
      host_wr(1, 400, 10'h3FF);
      host_rd(1, 144, d); chk(d == {cm_oe[144], cm_src[144]}, "R9 no alias", d, {cm_oe[144], cm_src[144]});
      host_rd(1, 400, d); chk(d == 0, "R9 cm read", d, 0);
      host_rd(0, 390, d); chk(d == 0, "R9 sample read", d, 0);
      settle_and_compare();

      finish_run();
   end
endmodule